// File: doc/BRIEF.md
# Cascadable Reloadable Interval Timer

This block is a 16-bit down-counting interval timer with a 16-bit reload latch. Software fills the latch one byte at a time through separate low-byte and high-byte write strobes. A control write sets the start bit, the one-shot bit and a 2-bit count-source select in one step. A force-load strobe copies the latch into the counter whenever it is asserted.

The counter moves by one on each qualifying tick while the start bit is set. A tick can be a system clock cycle, a rising edge on an external count pin, an underflow pulse from a companion timer, or such a companion underflow that arrives while the external pin is high. Stepping below zero reloads the counter from the latch. The same step produces a one-cycle underflow pulse, which can drive a further timer in the chain, and sets a sticky interrupt flag. A read strobe clears that flag.

Top module: `cascade_timer`

## Requirements
- R1: After reset the count is 0x0000, the start bit is 0, and both the underflow pulse and the interrupt flag are 0.
- R2: A low-byte latch write changes the latch and leaves the count unchanged.
- R3: A high-byte latch write while stopped loads the latch and, on the same edge, loads the counter with {written byte, low latch byte}.
- R4: A high-byte latch write while running updates only the latch. The count keeps decrementing, and the new latch value is used at the next underflow.
- R5: A force-load strobe copies the latch into the counter on the next edge.
- R6: Source select 00 decrements the count on every clock while running. While stopped, the count never changes.
- R7: Source select 01 decrements the count once for each rising edge of the external pin, after a two-flop synchroniser. Holding the pin high gives no further decrement.
- R8: Source select 10 decrements the count once for each cycle in which the companion underflow input is high.
- R9: Source select 11 decrements the count on companion underflows only while the synchronised external pin is high.
- R10: A tick at count 0x0000 reloads the counter from the latch and raises the underflow pulse for exactly one cycle.
- R11: An underflow sets the interrupt flag, which stays set until an interrupt-read strobe clears it. An underflow in the same cycle as the read leaves the flag set.
- R12: In one-shot mode the start bit clears at the underflow that reloads the counter. The count then holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| latchLoWr | input | 1 | Write strobe for the low latch byte |
| latchHiWr | input | 1 | Write strobe for the high latch byte |
| wrData | input | 8 | Byte written by either latch strobe |
| ctrlWr | input | 1 | Control write strobe |
| ctrlStart | input | 1 | Start bit value for a control write |
| ctrlOneShot | input | 1 | One-shot bit value for a control write |
| ctrlSrc | input | 2 | Count-source value for a control write |
| forceLoad | input | 1 | Copy the latch into the counter |
| extPin | input | 1 | External count pin (asynchronous) |
| cascUnder | input | 1 | Underflow pulse from the companion timer |
| irqRd | input | 1 | Interrupt flag read strobe (clears the flag) |
| count | output | 16 | Current counter value |
| running | output | 1 | Start bit |
| underPulse | output | 1 | One-cycle underflow pulse |
| irqFlag | output | 1 | Sticky interrupt flag |

## Verification
Two functions can land on one edge: setting the interrupt flag on an underflow, and clearing it on a read. The bench runs the count down to zero so that the underflowing tick lands on the edge where the read strobe is high. The flag must read as set after that edge and must still be set one cycle later. A second case writes the high latch byte while the counter is running. The count must keep stepping down, and the next reload must carry the newly written value.

// File: rtl/timer_pkg.sv
package timer_pkg;
  // Strobes passed from the control to the counter datapath.
  typedef struct packed {
    logic loadWr;  // load counter with freshly written high byte + low latch
    logic reload;  // load counter from latch (force or underflow)
    logic decr;    // count down by one
  } cntStrobe_t;

  typedef enum logic [1:0] {
    SRC_CLK   = 2'b00,
    SRC_PIN   = 2'b01,
    SRC_CASC  = 2'b10,
    SRC_GATED = 2'b11
  } cntSrc_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWr,
  input  logic       ctrlStart,
  input  logic       ctrlOneShot,
  input  logic [1:0] ctrlSrc,
  input  logic       latchHiWr,
  input  logic       forceLoad,
  input  logic       extPin,
  input  logic       cascUnder,
  input  logic       irqRd,
  input  logic       cntZero,
  output cntStrobe_t strobe,
  output logic       running,
  output logic       underPulse,
  output logic       irqFlag
);
  localparam int PIPE = SYNC_STAGES + 1;

  logic [PIPE-1:0] pinPipe;
  cntSrc_t         srcSel;
  logic            oneShot;
  logic            pinLevel;
  logic            pinRise;
  logic            tick;
  logic            underflow;

  // synchroniser plus one stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPipe <= '0;
    else       pinPipe <= {pinPipe[PIPE-2:0], extPin};
  end

  assign pinLevel = pinPipe[SYNC_STAGES-1];
  assign pinRise  = pinPipe[SYNC_STAGES-1] & ~pinPipe[SYNC_STAGES];

  always_comb begin
    unique case (srcSel)
      SRC_CLK:   tick = 1'b1;
      SRC_PIN:   tick = pinRise;
      SRC_CASC:  tick = cascUnder;
      SRC_GATED: tick = cascUnder & pinLevel;
      default:   tick = 1'b0;
    endcase
  end

  assign underflow     = running & tick & cntZero;
  assign strobe.decr   = running & tick & ~cntZero;
  assign strobe.reload = forceLoad | underflow;
  assign strobe.loadWr = latchHiWr & ~running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcSel     <= SRC_CLK;
      oneShot    <= 1'b0;
      running    <= 1'b0;
      underPulse <= 1'b0;
      irqFlag    <= 1'b0;
    end else begin
      underPulse <= underflow;
      if (underflow)  irqFlag <= 1'b1;
      else if (irqRd) irqFlag <= 1'b0;
      if (ctrlWr) begin
        srcSel  <= cntSrc_t'(ctrlSrc);
        oneShot <= ctrlOneShot;
        running <= ctrlStart;
      end else if (underflow && oneShot) begin
        running <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/timer_dp.sv
module timer_dp
  import timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              latchLoWr,
  input  logic              latchHiWr,
  input  logic [BYTE_W-1:0] wrData,
  input  cntStrobe_t        strobe,
  output logic [CNT_W-1:0]  count,
  output logic              cntZero
);
  localparam int HI_W = CNT_W - BYTE_W;

  logic [BYTE_W-1:0] latchLo;
  logic [HI_W-1:0]   latchHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchLo <= '0;
      latchHi <= '0;
    end else begin
      if (latchLoWr) latchLo <= wrData;
      if (latchHiWr) latchHi <= HI_W'(wrData);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              count <= '0;
    else if (strobe.loadWr) count <= {HI_W'(wrData), latchLo};
    else if (strobe.reload) count <= {latchHi, latchLo};
    else if (strobe.decr)   count <= count - 1'b1;
  end

  assign cntZero = (count == '0);
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              latchLoWr,
  input  logic              latchHiWr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              ctrlWr,
  input  logic              ctrlStart,
  input  logic              ctrlOneShot,
  input  logic [1:0]        ctrlSrc,
  input  logic              forceLoad,
  input  logic              extPin,
  input  logic              cascUnder,
  input  logic              irqRd,
  output logic [CNT_W-1:0]  count,
  output logic              running,
  output logic              underPulse,
  output logic              irqFlag
);
  cntStrobe_t strobe;
  logic       cntZero;

  timer_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlStart(ctrlStart),
    .ctrlOneShot(ctrlOneShot), .ctrlSrc(ctrlSrc), .latchHiWr(latchHiWr),
    .forceLoad(forceLoad), .extPin(extPin), .cascUnder(cascUnder),
    .irqRd(irqRd), .cntZero(cntZero), .strobe(strobe), .running(running),
    .underPulse(underPulse), .irqFlag(irqFlag)
  );

  timer_dp #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .latchLoWr(latchLoWr), .latchHiWr(latchHiWr),
    .wrData(wrData), .strobe(strobe), .count(count), .cntZero(cntZero)
  );
endmodule

// File: rtl/cascade_timer_chk.sv
module cascade_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             latchHiWr,
  input logic             forceLoad,
  input logic             irqRd,
  input logic [CNT_W-1:0] count,
  input logic             running,
  input logic             underPulse,
  input logic             irqFlag
);
  // R10: the pulse lasts one cycle
  a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    underPulse |=> !underPulse);

  // R10: a pulse only follows a zero count
  a_r10_from_zero: assert property (@(posedge clk) disable iff (!rstN)
    underPulse |-> ($past(count) == '0));

  // R11: the flag is set together with the pulse
  a_r11_flag_with_pulse: assert property (@(posedge clk) disable iff (!rstN)
    underPulse |-> irqFlag);

  // R11: the flag is sticky until read
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ($past(irqFlag) && !$past(irqRd)) |-> irqFlag);

  // R6: stopped with no load strobe means the count holds
  a_r6_hold_stopped: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!running) && $past(!forceLoad) && $past(!latchHiWr)) |-> $stable(count));
endmodule

bind cascade_timer cascade_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .latchHiWr(latchHiWr), .forceLoad(forceLoad),
  .irqRd(irqRd), .count(count), .running(running),
  .underPulse(underPulse), .irqFlag(irqFlag)
);

// File: tb/cascade_timer_bench.sv
module cascade_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        latchLoWr = 0, latchHiWr = 0;
  logic [7:0]  wrData = '0;
  logic        ctrlWr = 0, ctrlStart = 0, ctrlOneShot = 0;
  logic [1:0]  ctrlSrc = '0;
  logic        forceLoad = 0, extPin = 0, cascUnder = 0, irqRd = 0;
  logic [15:0] count;
  logic        running, underPulse, irqFlag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  cascade_timer u_cascade_timer (
    .clk(clk), .rstN(rstN), .latchLoWr(latchLoWr), .latchHiWr(latchHiWr),
    .wrData(wrData), .ctrlWr(ctrlWr), .ctrlStart(ctrlStart),
    .ctrlOneShot(ctrlOneShot), .ctrlSrc(ctrlSrc), .forceLoad(forceLoad),
    .extPin(extPin), .cascUnder(cascUnder), .irqRd(irqRd), .count(count),
    .running(running), .underPulse(underPulse), .irqFlag(irqFlag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setLatch(input logic [7:0] hi, input logic [7:0] lo);
    latchLoWr = 1; wrData = lo; step(1); latchLoWr = 0;
    latchHiWr = 1; wrData = hi; step(1); latchHiWr = 0;
  endtask

  task automatic ctl(input logic st, input logic os, input logic [1:0] src);
    ctrlWr = 1; ctrlStart = st; ctrlOneShot = os; ctrlSrc = src;
    step(1); ctrlWr = 0;
  endtask

  task automatic t_reset;
    chk("R1 count", count, 0);
    chk("R1 running", running, 0);
    chk("R1 pulse", underPulse, 0);
    chk("R1 irq", irqFlag, 0);
  endtask

  task automatic t_latchWrites;
    latchLoWr = 1; wrData = 8'h34; step(1); latchLoWr = 0;
    chk("R2 low write no load", count, 0);
    latchHiWr = 1; wrData = 8'h12; step(1); latchHiWr = 0;
    chk("R3 high write stopped loads", count, 16'h1234);
  endtask

  task automatic t_clockSource;
    setLatch(8'h00, 8'h03);
    chk("R3 reload value", count, 3);
    step(3);
    chk("R6 stopped holds", count, 3);
    ctl(1, 0, 2'b00);
    chk("R6 start", running, 1);
    step(3);
    chk("R6 count per clock", count, 0);
    step(1);
    chk("R10 reload", count, 3);
    chk("R10 pulse high", underPulse, 1);
    chk("R11 flag set", irqFlag, 1);
    step(1);
    chk("R10 pulse one cycle", underPulse, 0);
    chk("R10 counting resumed", count, 2);
    ctl(0, 0, 2'b00);
    irqRd = 1; step(1); irqRd = 0;
    chk("R11 read clears", irqFlag, 0);
  endtask

  task automatic t_hiRunning;
    setLatch(8'h00, 8'h0A);
    ctl(1, 0, 2'b00);
    latchLoWr = 1; wrData = 8'h02; step(1); latchLoWr = 0;
    chk("R4 count before", count, 9);
    latchHiWr = 1; wrData = 8'h00; step(1); latchHiWr = 0;
    chk("R4 high write running untouched", count, 8);
    step(8);
    chk("R4 reached zero", count, 0);
    step(1);
    chk("R4 new latch used", count, 2);
    ctl(0, 0, 2'b00);
    chk("R6 stopped", running, 0);
  endtask

  task automatic t_collision;
    irqRd = 1; step(1); irqRd = 0;
    chk("R11 cleared", irqFlag, 0);
    setLatch(8'h00, 8'h02);
    ctl(1, 0, 2'b00);
    step(2);
    chk("R11 at zero", count, 0);
    irqRd = 1; step(1); irqRd = 0;
    chk("R11 set wins over read", irqFlag, 1);
    step(1);
    chk("R11 still set", irqFlag, 1);
    irqRd = 1; step(1); irqRd = 0;
    chk("R11 cleared after", irqFlag, 0);
    ctl(0, 0, 2'b00);
  endtask

  task automatic t_oneShot;
    setLatch(8'h00, 8'h01);
    ctl(1, 1, 2'b00);
    step(1);
    chk("R12 counted", count, 0);
    step(1);
    chk("R12 reload", count, 1);
    chk("R12 start cleared", running, 0);
    step(3);
    chk("R12 holds", count, 1);
  endtask

  task automatic t_force;
    latchLoWr = 1; wrData = 8'h20; step(1); latchLoWr = 0;
    chk("R2 low write no load", count, 1);
    forceLoad = 1; step(1); forceLoad = 0;
    chk("R5 force load", count, 16'h0020);
  endtask

  task automatic t_extPin;
    setLatch(8'h00, 8'h05);
    ctl(1, 0, 2'b01);
    extPin = 1; step(6);
    chk("R7 one edge", count, 4);
    step(4);
    chk("R7 level no recount", count, 4);
    extPin = 0; step(4);
    extPin = 1; step(6);
    chk("R7 second edge", count, 3);
    extPin = 0; step(4);
  endtask

  task automatic t_cascade;
    ctl(1, 0, 2'b10);
    step(3);
    chk("R8 idle holds", count, 3);
    cascUnder = 1; step(1); cascUnder = 0;
    chk("R8 one pulse", count, 2);
    step(2);
    cascUnder = 1; step(1); cascUnder = 0;
    chk("R8 second pulse", count, 1);
  endtask

  task automatic t_gated;
    ctl(1, 0, 2'b11);
    step(4);
    cascUnder = 1; step(1); cascUnder = 0;
    chk("R9 pin low blocks", count, 1);
    extPin = 1; step(4);
    cascUnder = 1; step(1); cascUnder = 0;
    chk("R9 pin high passes", count, 0);
    ctl(0, 0, 2'b00);
    extPin = 0;
  endtask

  initial begin
    step(3);
    t_reset();
    rstN = 1;
    step(1);
    t_reset();
    t_latchWrites();
    t_clockSource();
    t_hiRunning();
    t_collision();
    t_oneShot();
    t_force();
    t_extPin();
    t_cascade();
    t_gated();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule